// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

This block watches general-purpose input pins and turns their edges into interrupt requests and event pulses. It has sixteen lines. Each line can only see pin n of one input port, and a per-line port selector chooses which port that is. Every input goes through a two-flop synchronizer. Edge detection then runs on the selected, synchronized level.

Each line has its own rising-trigger and falling-trigger enable. A rising edge that is detected sets the line's rising pending flag, and a falling edge that is detected sets its falling pending flag. Software clears each flag on its own by writing a one. The interrupt request of a line is the OR of its two flags, gated by that line's interrupt mask bit. When the event mask bit is set, a detected edge also gives a one-clock event pulse. The two masks are independent of each other.

Software reaches the controller through a simple word-addressed register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and irq_o and evt_o are low. The register map uses word addresses, and in each register bit n belongs to line n:
  - 0: rising-trigger enable
  - 1: falling-trigger enable
  - 2: interrupt mask
  - 3: event mask
  - 4: rising pending
  - 5: falling pending
  - 8 to 11: port selectors
- R2: With its rising enable set, a 0-to-1 change on a line's selected pin sets that line's rising pending bit. The bit becomes visible after the third rising clock edge that samples the new level.
- R3: With its falling enable set, a 1-to-0 change sets the falling pending bit with the same latency. It leaves the rising pending bit unchanged.
- R4: An edge whose trigger enable is clear sets no pending bit.
- R5: With both enables set, rising edges and falling edges are each recorded in their own pending flag.
- R6: Writing 1 to a bit of address 4 or 5 clears that pending bit. Writing 0 leaves it unchanged.
- R7: When a clear write and a newly detected edge land on the same clock edge, the pending bit stays set.
- R8: irq_o[n] is high exactly when line n has either pending bit set and its interrupt mask bit is 1.
- R9: A detected edge gives a one-cycle evt_o[n] pulse, in the cycle the pending bit sets, only when the event mask bit is 1. The interrupt mask has no effect on it.
- R10: Selector register 8+k holds lines 4k to 4k+3. The selector of line n sits in bits [8*(n%4)+3 : 8*(n%4)]. Line n follows gpio_in bit p*16+n, where p is its selector value, and ignores every other port.
- R11: Changing a line's selector does not by itself create an edge, even when the newly selected pin has a different level. Later edges on the new pin are detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 256 | Port p, pin n at bit p*16+n; asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_o | output | 16 | Per-line interrupt request |
| evt_o | output | 16 | Per-line one-cycle event pulse |

## Verification
Two situations are hard to reach from the ports. The first is a clear write that lands on the exact edge where a new edge sets the flag. The bench gets there by counting synchronizer stages from a pin change, so the write strobe is raised in the cycle just before the third sampling edge. The second is a selector switch between two ports that sit at different levels. The bench first parks the two ports at opposite levels and lets them settle. It then rewrites the selector and checks that no flag appears. Finally it drives an edge on the new pin to show that the new source is live.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
   // word addresses of the register file
   localparam int unsigned ADR_RISE_EN   = 0;
   localparam int unsigned ADR_FALL_EN   = 1;
   localparam int unsigned ADR_IRQ_MASK  = 2;
   localparam int unsigned ADR_EVT_MASK  = 3;
   localparam int unsigned ADR_RISE_PEND = 4;
   localparam int unsigned ADR_FALL_PEND = 5;
   localparam int unsigned ADR_SEL_BASE  = 8;
   // selector packing: lines per selector word
   localparam int unsigned LINES_PER_SEL = 4;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("edge_sync needs at least two stages");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d_i;
         for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/edge_line.sv
module edge_line #(
   parameter int unsigned NPORTS = 16,
   parameter int unsigned SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPORTS-1:0] pins_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              sel_chg_i,
   input  logic              rise_en_i,
   input  logic              fall_en_i,
   input  logic              evt_en_i,
   input  logic              clr_rise_i,
   input  logic              clr_fall_i,
   output logic              rise_pend_o,
   output logic              fall_pend_o,
   output logic              evt_o
);
   localparam int unsigned FULL = 1 << SEL_W;

   logic cur, prev, hold, rise_hit, fall_hit;

   if (NPORTS == FULL) begin : g_full_mux
      assign cur = pins_i[sel_i];
   end else begin : g_part_mux
      logic [FULL-1:0] padded;
      assign padded = FULL'(pins_i);
      assign cur    = padded[sel_i];
   end

   // one cycle after a selector change, re-seed prev without detecting
   assign rise_hit = !hold &&  cur && !prev && rise_en_i;
   assign fall_hit = !hold && !cur &&  prev && fall_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev        <= 1'b0;
         hold        <= 1'b0;
         rise_pend_o <= 1'b0;
         fall_pend_o <= 1'b0;
         evt_o       <= 1'b0;
      end else begin
         prev        <= cur;
         hold        <= sel_chg_i;
         rise_pend_o <= rise_hit | (rise_pend_o & ~clr_rise_i);
         fall_pend_o <= fall_hit | (fall_pend_o & ~clr_fall_i);
         evt_o       <= (rise_hit | fall_hit) & evt_en_i;
      end
   end
endmodule

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs
   import edge_irq_pkg::*;
#(
   parameter int unsigned NLINES = 16,
   parameter int unsigned SEL_W  = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   output logic [DATA_W-1:0]       rdata_o,
   input  logic [NLINES-1:0]       rise_pend_i,
   input  logic [NLINES-1:0]       fall_pend_i,
   output logic [NLINES-1:0]       rise_en_o,
   output logic [NLINES-1:0]       fall_en_o,
   output logic [NLINES-1:0]       imask_o,
   output logic [NLINES-1:0]       emask_o,
   output logic [NLINES*SEL_W-1:0] sel_o,
   output logic [NLINES-1:0]       sel_chg_o,
   output logic [NLINES-1:0]       clr_rise_o,
   output logic [NLINES-1:0]       clr_fall_o
);
   localparam int unsigned SLOT_W  = DATA_W / LINES_PER_SEL;
   localparam int unsigned NSELREG = NLINES / LINES_PER_SEL;

   localparam logic [ADDR_W-1:0] A_RE = ADDR_W'(ADR_RISE_EN);
   localparam logic [ADDR_W-1:0] A_FE = ADDR_W'(ADR_FALL_EN);
   localparam logic [ADDR_W-1:0] A_IM = ADDR_W'(ADR_IRQ_MASK);
   localparam logic [ADDR_W-1:0] A_EM = ADDR_W'(ADR_EVT_MASK);
   localparam logic [ADDR_W-1:0] A_RP = ADDR_W'(ADR_RISE_PEND);
   localparam logic [ADDR_W-1:0] A_FP = ADDR_W'(ADR_FALL_PEND);

   if (SEL_W > SLOT_W) begin : g_bad_slot
      $error("selector field wider than its slot");
   end

   logic [NLINES-1:0] wbits;
   assign wbits = wdata_i[NLINES-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en_o <= '0;
         fall_en_o <= '0;
         imask_o   <= '0;
         emask_o   <= '0;
      end else if (we_i) begin
         if (addr_i == A_RE) rise_en_o <= wbits;
         if (addr_i == A_FE) fall_en_o <= wbits;
         if (addr_i == A_IM) imask_o   <= wbits;
         if (addr_i == A_EM) emask_o   <= wbits;
      end
   end

   assign clr_rise_o = (we_i && addr_i == A_RP) ? wbits : '0;
   assign clr_fall_o = (we_i && addr_i == A_FP) ? wbits : '0;

   for (genvar n = 0; n < NLINES; n++) begin : g_sel
      localparam int unsigned REG  = n / LINES_PER_SEL;
      localparam int unsigned SLOT = n % LINES_PER_SEL;
      logic [SEL_W-1:0] sel_q, sel_new;
      logic             hit;
      assign sel_new = wdata_i[SLOT*SLOT_W +: SEL_W];
      assign hit     = we_i && (addr_i == ADDR_W'(ADR_SEL_BASE + REG));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   sel_q <= '0;
         else if (hit) sel_q <= sel_new;
      end
      assign sel_chg_o[n]              = hit && (sel_new != sel_q);
      assign sel_o[n*SEL_W +: SEL_W]   = sel_q;
   end

   logic [NSELREG-1:0][DATA_W-1:0] sel_word;

   always_comb begin
      sel_word = '0;
      for (int k = 0; k < int'(NSELREG); k++)
         for (int j = 0; j < int'(LINES_PER_SEL); j++)
            sel_word[k][j*SLOT_W +: SEL_W] = sel_o[(k*LINES_PER_SEL+j)*SEL_W +: SEL_W];
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_RE:    rdata_o = DATA_W'(rise_en_o);
         A_FE:    rdata_o = DATA_W'(fall_en_o);
         A_IM:    rdata_o = DATA_W'(imask_o);
         A_EM:    rdata_o = DATA_W'(emask_o);
         A_RP:    rdata_o = DATA_W'(rise_pend_i);
         A_FP:    rdata_o = DATA_W'(fall_pend_i);
         default: begin
            for (int k = 0; k < int'(NSELREG); k++)
               if (addr_i == ADDR_W'(ADR_SEL_BASE + k)) rdata_o = sel_word[k];
         end
      endcase
   end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int unsigned NLINES      = 16,
   parameter int unsigned NPORTS      = 16,
   parameter int unsigned SEL_W       = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPORTS*NLINES-1:0] gpio_in,
   input  logic                     reg_we,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic [NLINES-1:0]        irq_o,
   output logic [NLINES-1:0]        evt_o
);
   localparam int unsigned NSELREG = NLINES / LINES_PER_SEL;

   if (NLINES > DATA_W) begin : g_bad_lines
      $error("more lines than data bits");
   end
   if (NLINES % LINES_PER_SEL != 0) begin : g_bad_pack
      $error("line count must fill whole selector words");
   end
   if (NPORTS > (1 << SEL_W)) begin : g_bad_ports
      $error("selector too narrow for port count");
   end
   if (ADR_SEL_BASE + NSELREG > (1 << ADDR_W)) begin : g_bad_addr
      $error("address space too small");
   end

   logic [NPORTS*NLINES-1:0] gpio_s;
   logic [NLINES-1:0]        rise_en, fall_en, imask, emask;
   logic [NLINES-1:0]        rise_pend, fall_pend, sel_chg, clr_rise, clr_fall;
   logic [NLINES*SEL_W-1:0]  sel;

   edge_sync #(.WIDTH(NPORTS*NLINES), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i(gpio_in), .q_o(gpio_s)
   );

   edge_cfg_regs #(.NLINES(NLINES), .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
      .rdata_o(reg_rdata), .rise_pend_i(rise_pend), .fall_pend_i(fall_pend),
      .rise_en_o(rise_en), .fall_en_o(fall_en), .imask_o(imask), .emask_o(emask),
      .sel_o(sel), .sel_chg_o(sel_chg), .clr_rise_o(clr_rise), .clr_fall_o(clr_fall)
   );

   for (genvar n = 0; n < NLINES; n++) begin : g_line
      logic [NPORTS-1:0] pins;
      for (genvar p = 0; p < NPORTS; p++) begin : g_pin
         assign pins[p] = gpio_s[p*NLINES + n];
      end
      edge_line #(.NPORTS(NPORTS), .SEL_W(SEL_W)) i_line (
         .clk(clk), .rst_n(rst_n), .pins_i(pins), .sel_i(sel[n*SEL_W +: SEL_W]),
         .sel_chg_i(sel_chg[n]), .rise_en_i(rise_en[n]), .fall_en_i(fall_en[n]),
         .evt_en_i(emask[n]), .clr_rise_i(clr_rise[n]), .clr_fall_i(clr_fall[n]),
         .rise_pend_o(rise_pend[n]), .fall_pend_o(fall_pend[n]), .evt_o(evt_o[n])
      );
   end

   assign irq_o = (rise_pend | fall_pend) & imask;
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk
   import edge_irq_pkg::*;
#(
   parameter int unsigned NLINES = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [NLINES-1:0] rise_en,
   input logic [NLINES-1:0] fall_en,
   input logic [NLINES-1:0] imask,
   input logic [NLINES-1:0] emask,
   input logic [NLINES-1:0] rise_pend,
   input logic [NLINES-1:0] fall_pend,
   input logic [NLINES-1:0] irq_o,
   input logic [NLINES-1:0] evt_o
);
   a_r2_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_pend & ~$past(rise_pend) & ~$past(rise_en)) == '0));

   a_r3_fall_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ((fall_pend & ~$past(fall_pend) & ~$past(fall_en)) == '0));

   a_r6_zero_keeps_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(ADR_RISE_PEND)) |=>
      ((~rise_pend & $past(rise_pend) & ~$past(reg_wdata[NLINES-1:0])) == '0));

   a_r6_zero_keeps_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(ADR_FALL_PEND)) |=>
      ((~fall_pend & $past(fall_pend) & ~$past(reg_wdata[NLINES-1:0])) == '0));

   a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_o & ~imask) == '0));

   a_r9_evt_marks_pending: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_o & ~(rise_pend | fall_pend)) == '0));

   a_r9_evt_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_o & ~$past(emask)) == '0));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.NLINES(NLINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .rise_en(rise_en), .fall_en(fall_en), .imask(imask), .emask(emask),
   .rise_pend(rise_pend), .fall_pend(fall_pend), .irq_o(irq_o), .evt_o(evt_o)
);

// File: tb/test_edge_irq_ctrl.sv
module test_edge_irq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 16;
   localparam int NP = 16;

   // vector: {line, selector value, driven port}
   localparam logic [11:0] VEC [0:6] = '{12'h000, 12'h001, 12'h577, 12'h576,
                                         12'hFFF, 12'hA3C, 12'h944};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP*NL-1:0] gpio_in = '0;
   logic            reg_we = 1'b0;
   logic [3:0]      reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NL-1:0]   irq_o, evt_o;
   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edge_irq_ctrl i_edge_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .evt_o(evt_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 4'(a);
      #1;
      d = reg_rdata;
   endtask

   task automatic pin(input int p, input int n, input logic v);
      @(negedge clk);
      gpio_in[p*NL+n] = v;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [31:0] v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 12; a++) begin
         if (a == 6 || a == 7) continue;
         rd(a, v);
         chk($sformatf("R1 reset reg %0d", a), v, 32'h0);
      end
      chk("R1 reset irq/evt", {irq_o, evt_o}, 32'h0);

      // R10 table walk (rising edges, R2 path)
      wr(0, 32'hFFFF);
      for (int i = 0; i < 7; i++) begin
         int ln, sl, dp;
         logic [31:0] exp;
         ln = int'(VEC[i][11:8]); sl = int'(VEC[i][7:4]); dp = int'(VEC[i][3:0]);
         exp = (sl == dp) ? (32'h1 << ln) : 32'h0;
         wr(8 + ln/4, 32'(sl) << (8*(ln%4)));
         settle();
         wr(4, 32'hFFFF);
         pin(dp, ln, 1'b1);
         settle();
         rd(4, v);
         chk($sformatf("R10 vec %0d line %0d sel %0d port %0d", i, ln, sl, dp), v, exp);
         pin(dp, ln, 1'b0);
         settle();
         wr(4, 32'hFFFF);
      end
      wr(8, 32'h0); wr(9, 32'h0); wr(10, 32'h0); wr(11, 32'h0);
      rd(8, v);
      chk("R10 selector readback", v, 32'h0);
      settle();
      wr(4, 32'hFFFF); wr(5, 32'hFFFF);

      // R4: triggers disabled
      wr(0, 32'h0); wr(1, 32'h0);
      pin(0, 3, 1'b1); settle();
      rd(4, v); rd(5, v2);
      chk("R4 disabled trigger", {v[15:0], v2[15:0]}, 32'h0);
      pin(0, 3, 1'b0); settle();

      // R2 + R9: rising edge with event mask
      wr(0, 32'h8); wr(3, 32'h8); wr(2, 32'h0);
      pin(0, 3, 1'b1);
      repeat (3) @(negedge clk);
      chk("R9 event pulse", 32'(evt_o), 32'h8);
      rd(4, v);
      chk("R2 rise pending", v, 32'h8);
      chk("R8 irq masked off", 32'(irq_o), 32'h0);
      @(negedge clk);
      chk("R9 event one cycle", 32'(evt_o), 32'h0);

      // R8: unmask
      wr(2, 32'h8);
      chk("R8 irq from rise flag", 32'(irq_o), 32'h8);

      // R6: write-one-to-clear
      wr(4, 32'h0);
      rd(4, v);
      chk("R6 zero write no effect", v, 32'h8);
      wr(4, 32'h8);
      rd(4, v);
      chk("R6 one write clears", v, 32'h0);
      chk("R8 irq drops", 32'(irq_o), 32'h0);

      // R3 + R9 masked: falling edge, no event
      wr(1, 32'h8); wr(3, 32'h0);
      pin(0, 3, 1'b0);
      repeat (3) @(negedge clk);
      chk("R9 no event when masked", 32'(evt_o), 32'h0);
      @(negedge clk);
      rd(5, v); rd(4, v2);
      chk("R3 fall pending", v, 32'h8);
      chk("R3 rise untouched", v2, 32'h0);
      chk("R8 irq from fall flag", 32'(irq_o), 32'h8);

      // R5: both edges
      wr(4, 32'hFFFF); wr(5, 32'hFFFF);
      pin(0, 3, 1'b1); settle();
      rd(4, v); rd(5, v2);
      chk("R5 rise seen", {v[15:0], v2[15:0]}, {16'h8, 16'h0});
      pin(0, 3, 1'b0); settle();
      rd(5, v2);
      chk("R5 fall seen", v2, 32'h8);

      // R7: clear and new edge on the same clock edge
      wr(4, 32'hFFFF); wr(5, 32'hFFFF);
      pin(0, 3, 1'b1);
      repeat (2) @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h8;
      @(negedge clk);
      reg_we = 1'b0;
      rd(4, v);
      chk("R7 edge beats clear", v, 32'h8);

      // R11: selector switch with differing levels
      pin(0, 3, 1'b0);
      pin(2, 3, 1'b1);
      settle();
      wr(4, 32'hFFFF); wr(5, 32'hFFFF);
      wr(0, 32'h8); wr(1, 32'h8);
      wr(8, 32'h2 << 24);
      settle();
      rd(4, v); rd(5, v2);
      chk("R11 no false edge on select", {v[15:0], v2[15:0]}, 32'h0);
      pin(2, 3, 1'b0); settle();
      rd(5, v2);
      chk("R11 new source live", v2, 32'h8);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule